// File: doc/BRIEF.md
# Skewed-Counter Output Realigner

A counter whose carry is passed from one bit to the next through a single register per stage runs fast, but its outputs arrive out of step: bit k shows the count as it stood k clocks earlier. This block takes those skewed bits and delays each one so that all of them match the most-delayed bit, the top bit. Its output is an ordinary binary word that trails the ideal count by a fixed WIDTH-1 clocks.

When the counter runs freely, bit k repeats with a period of 2^(k+1) clocks. A delay of any whole number of periods therefore changes nothing. Each bit's alignment delay is reduced modulo its own period, and the reduced length is computed from WIDTH at elaboration. A reduced length of zero is a plain wire. Any other length is a shift register that reset clears. The counting enable drives every delay stage in parallel, so gaps in counting keep the bits aligned. A flag marks the output valid once the pipeline has filled.

Top module: `skew_realign`

## Requirements
- R1: While reset is high and on the first cycle after it, `aligned_valid` is 0 and every delay stage holds 0. With all-zero skewed inputs, `aligned` then reads 0.
- R2: Bit k of `aligned` is bit k of `skew_bits` delayed by (WIDTH-1-k) mod 2^(k+1) enabled clock edges. Bit WIDTH-1 passes through with no register. For WIDTH=8 the delays of bits 0 to 7 are 1, 2, 5, 4, 3, 2, 1, 0.
- R3: `aligned_valid` rises on the (WIDTH-1)-th enabled clock edge after reset. It stays high until the next reset.
- R4: The input encoding is that bit k of `skew_bits` equals bit k of a count c taken k enabled steps earlier, and is 0 before c has taken k steps. Under that encoding, when `aligned_valid` is high, `aligned` equals (c - (WIDTH-1)) mod 2^WIDTH.
- R5: While valid, each enabled edge raises `aligned` by exactly one. The value wraps from 2^WIDTH-1 to 0.
- R6: With `en` low, no delay stage shifts and the valid timer does not advance. With the inputs held, `aligned` and `aligned_valid` stay unchanged.
- R7: If the enable is stopped and restarted at arbitrary points, and the inputs advance only on enabled steps, R4 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, shared by every delay stage and the valid timer |
| skew_bits | input | WIDTH | Time-skewed outputs of the pipelined-carry counter |
| aligned | output | WIDTH | Realigned binary count |
| aligned_valid | output | 1 | High once `aligned` carries a true count |

## Verification
Bit WIDTH-1 of `aligned` is combinational from its input. Every other bit k follows its input after exactly its reduced delay in enabled edges. `aligned_valid` is registered and goes high on the (WIDTH-1)-th enabled edge. The bench changes inputs 1 ns after a rising edge and samples at the following falling edge. At each sample it compares against the count held by its own skewed-counter model: `aligned` must equal the model count minus WIDTH-1. For the delay test, all skewed inputs are held at 1, and bit k must first read 1 after exactly its reduced delay in edges.

// File: rtl/skew_realign_pkg.sv
package skew_realign_pkg;

    // Alignment delay of bit k in an n-bit skewed counter, reduced
    // modulo the bit's toggle period 2^(k+1).
    function automatic int unsigned align_depth(input int unsigned n, input int unsigned k);
        int unsigned raw_len;
        raw_len = n - 1 - k;
        if (k >= 30)
            return raw_len;          // period exceeds any possible raw length
        return raw_len % (32'd1 << (k + 1));
    endfunction

endpackage

// File: rtl/skew_delay_line.sv
module skew_delay_line #(
    parameter int unsigned DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [DEPTH-1:0] taps;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en)
            st_d.taps = DEPTH'({st_q.taps, din});
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.taps[DEPTH-1];

    // R2: an enabled edge captures the input into the first stage
    a_r2_entry: assert property (@(posedge clk) disable iff (rst)
        en |=> (st_q.taps[0] == $past(din)));

    // R6: a disabled edge leaves every stage untouched
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q.taps));

endmodule

// File: rtl/skew_valid_timer.sv
module skew_valid_timer #(
    parameter int unsigned LATENCY = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic valid
);

    localparam int unsigned CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] LAST = CW'(LATENCY);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          valid;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (en && (tm_q.count != LAST))
            tm_d.count = tm_q.count + 1'b1;
        tm_d.valid = (tm_d.count == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) tm_q <= '0;
        else     tm_q <= tm_d;
    end

    assign valid = tm_q.valid;

    // R3: once valid, stays valid until reset
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        tm_q.valid |=> tm_q.valid);

    // R3: valid rises only on the enabled edge that completes the latency
    a_r3_rise_point: assert property (@(posedge clk) disable iff (rst)
        $rose(tm_q.valid) |-> ($past(en) && ($past(tm_q.count) == LAST - 1'b1)));

    // R6: timer frozen while disabled
    a_r6_timer_frozen: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(tm_q.count));

endmodule

// File: rtl/skew_realign.sv
module skew_realign
    import skew_realign_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] skew_bits,
    output logic [WIDTH-1:0] aligned,
    output logic             aligned_valid
);

    localparam int unsigned LATENCY = WIDTH - 1;

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        localparam int unsigned D = align_depth(WIDTH, k);
        if (D == 0) begin : g_wire
            assign aligned[k] = skew_bits[k];
        end else begin : g_line
            skew_delay_line #(.DEPTH(D)) u_line (
                .clk  (clk),
                .rst  (rst),
                .en   (en),
                .din  (skew_bits[k]),
                .dout (aligned[k])
            );
        end
    end

    skew_valid_timer #(.LATENCY(LATENCY)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .valid (aligned_valid)
    );

    // R5: a valid word advances by one per enabled edge, wrapping at 2^WIDTH
    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
        (aligned_valid && $past(aligned_valid) && $past(en))
            |-> (aligned == WIDTH'($past(aligned) + 1'b1)));

    // R6: with counting paused the valid word does not move
    a_r6_word_still: assert property (@(posedge clk) disable iff (rst)
        (aligned_valid && $past(aligned_valid) && !$past(en)) |-> $stable(aligned));

endmodule

// File: tb/skew_realign_test.sv
module skew_realign_test;

    localparam int unsigned N      = 8;
    localparam int unsigned LAT    = N - 1;
    localparam time         PERIOD = 10;
    localparam int          NSTEP  = 6;
    // each entry: {enable, number of cycles}
    localparam logic [8:0] PLAN [0:NSTEP-1] = '{
        {1'b1, 8'd4}, {1'b0, 8'd3}, {1'b1, 8'd5},
        {1'b0, 8'd2}, {1'b1, 8'd9}, {1'b0, 8'd4}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [N-1:0] skew_bits = '0;
    logic [N-1:0] aligned;
    logic         aligned_valid;

    int checks = 0;
    int fails  = 0;
    int s      = 0;
    logic [N-1:0] prev_word = '0;
    logic         prev_valid = 1'b0;
    bit  done = 0;

    skew_realign #(.WIDTH(N)) uut (
        .clk(clk), .rst(rst), .en(en), .skew_bits(skew_bits),
        .aligned(aligned), .aligned_valid(aligned_valid)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [N-1:0] model_bits(input int step);
        logic [N-1:0] v = '0;
        for (int k = 0; k < N; k++)
            if (step >= k) v[k] = 1'(((step - k) >> k) & 1);
        return v;
    endfunction

    function automatic int exp_depth(input int k);
        return (N - 1 - k) % (1 << (k + 1));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0; s = 0; skew_bits = '0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 valid", aligned_valid, 0);
        check("R1 word", aligned, 0);
        prev_word = aligned; prev_valid = aligned_valid;
    endtask

    task automatic tick(input logic e, input string tag);
        en = e;
        @(posedge clk);
        #1;
        if (e) s++;
        skew_bits = model_bits(s);
        @(negedge clk);
        check({tag, " R3 valid"}, aligned_valid, (s >= LAT));
        if (s >= LAT)
            check({tag, " word"}, aligned, N'(s - LAT));
        if (!e)
            check("R6 hold", {aligned_valid, aligned}, {prev_valid, prev_word});
        else if (prev_valid) begin
            check("R5 step", aligned, N'(prev_word + 1'b1));
            if (prev_word == '1) check("R5 wrap", aligned, 0);
        end
        prev_word = aligned; prev_valid = aligned_valid;
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R7: enable gaps taken from the table
        do_reset();
        for (int i = 0; i < NSTEP; i++)
            repeat (int'(PLAN[i][7:0])) tick(PLAN[i][8], "R7");

        // R2: hold every input at 1 and time each bit's first 1
        do_reset();
        skew_bits = '1;
        #1;
        for (int step = 0; step < LAT; step++) begin
            logic [N-1:0] exp_w;
            if (step > 0) begin
                en = 1'b1;
                @(posedge clk);
                #1;
            end
            @(negedge clk);
            for (int k = 0; k < N; k++) exp_w[k] = (step >= exp_depth(k));
            check("R2 depth", aligned, exp_w);
            check("R3 not yet", aligned_valid, 0);
        end
        @(posedge clk);
        @(negedge clk);
        check("R3 rise", aligned_valid, 1);

        // R4: free run past a full wrap
        do_reset();
        for (int c = 0; c < (1 << N) + N + 4; c++) tick(1'b1, "R4");
        tick(1'b0, "R4");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule